// File: doc/BRIEF.md
# Comparator Output Conditioner with Edge Interrupt

This block takes the raw one-bit decisions of a set of analog comparators (two by default). It turns each one into a conditioned digital output. The raw decision is brought into the system clock domain by a two-flop synchronizer. The compare term is then forced low while that comparator is disabled, and an optional polarity inversion is applied after that. The result can be held in a capture register that loads only on a falling edge of the timer source clock, so that a timer counting on the rising edge never sees the output move mid-count. With synchronous mode off, the polarity-adjusted value goes straight to the output.

Each conditioned output drives three things:
- an internal output;
- a pin output, which is gated by its own output enable and by nothing else;
- one bit of a read-only status mirror.

Two edge detectors watch each conditioned output, one for rising and one for falling transitions. Each has its own enable. An enabled edge sets a sticky interrupt flag, which holds until a software clear strobe removes it. An edge that arrives in the same cycle as the clear wins.

Top module: `cmp_cond`

## Requirements
- R1: After reset every interrupt flag is 0. The edge history and the sync capture register are 0. With enable and polarity at 0, every conditioned output, pin output and mirror bit is 0.
- R2: Two system clock edges after the raw compare input changes, the conditioned output follows it. With polarity 0 it equals the raw compare (1 = positive input above negative input). With polarity 1 it is the inverse.
- R3: With sync mode 1, the conditioned output changes only after a falling edge of the timer source clock. That edge is brought in through two flops and captures the polarity-adjusted value. A rising timer clock edge or a raw change alone leaves the output unchanged. With sync mode 0 the polarity-adjusted value passes directly.
- R4: A 0-to-1 change of the conditioned output sets the comparator's interrupt flag at the next clock edge only when its rising-edge enable is 1. With that enable at 0 the flag stays 0.
- R5: A 1-to-0 change of the conditioned output sets the flag at the next clock edge only when its falling-edge enable is 1. With that enable at 0 the flag stays 0.
- R6: A set flag stays set until its clear strobe is sampled high, and is then 0. If an enabled edge occurs in the same cycle as the clear, the flag is 1 afterwards.
- R7: While a comparator is disabled, its compare term is 0 before polarity is applied. Its output then equals its polarity bit. Toggling the polarity bit or the enable bit still moves the output and can set the flag.
- R8: The pin output equals the conditioned output when output enable is 1, and is 0 otherwise. This holds whether the comparator is enabled or not.
- R9: The mirror output carries the conditioned output of comparator k in bit k (bit 1 = second comparator, bit 0 = first). All bits above the comparator count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_cmp | input | N_CMP | Raw comparator decisions (asynchronous) |
| tmr_clk | input | 1 | Timer source clock after prescaler (asynchronous) |
| cfg_en | input | N_CMP | Comparator enable, one per comparator |
| cfg_pol | input | N_CMP | Output polarity invert |
| cfg_oe | input | N_CMP | Pin output enable |
| cfg_sync | input | N_CMP | Synchronous (timer-captured) output mode |
| cfg_int_rise | input | N_CMP | Rising-edge interrupt enable |
| cfg_int_fall | input | N_CMP | Falling-edge interrupt enable |
| flag_clr | input | N_CMP | Interrupt flag clear strobe |
| cmp_out | output | N_CMP | Conditioned outputs |
| pin_out | output | N_CMP | Gated pin outputs |
| mirror | output | MIRROR_W | Status mirror of conditioned outputs |
| irq_flag | output | N_CMP | Sticky interrupt flags |

## Verification
The bench targets the collision of a clear strobe with an enabled edge. A design that lets the clear win would drop that interrupt. It also checks that a rising timer clock edge in synchronous mode leaves the output alone; a design that captured on the wrong edge would move the output there. With a comparator disabled, it confirms that toggling the polarity bit still moves the output and raises the flag; a design that forced the output low after polarity would miss both. It also confirms that each edge enable suppresses only its own direction, and that the pin gate ignores the comparator enable.

// File: rtl/cmp_cond.sv
module cmp_cond #(
  parameter int N_CMP    = 2,
  parameter int MIRROR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_CMP-1:0]    raw_cmp,
  input  logic                tmr_clk,
  input  logic [N_CMP-1:0]    cfg_en,
  input  logic [N_CMP-1:0]    cfg_pol,
  input  logic [N_CMP-1:0]    cfg_oe,
  input  logic [N_CMP-1:0]    cfg_sync,
  input  logic [N_CMP-1:0]    cfg_int_rise,
  input  logic [N_CMP-1:0]    cfg_int_fall,
  input  logic [N_CMP-1:0]    flag_clr,
  output logic [N_CMP-1:0]    cmp_out,
  output logic [N_CMP-1:0]    pin_out,
  output logic [MIRROR_W-1:0] mirror,
  output logic [N_CMP-1:0]    irq_flag
);

  localparam int PAD_W = MIRROR_W - N_CMP;

  logic [1:0] tclk_s;
  logic       tclk_d;
  logic       tmr_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tclk_s <= '0;
      tclk_d <= 1'b0;
    end else begin
      tclk_s <= {tclk_s[0], tmr_clk};
      tclk_d <= tclk_s[1];
    end

  assign tmr_fall = tclk_d & ~tclk_s[1];

  logic [N_CMP-1:0] raw_s1, raw_s2, pol_val, held, hist;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      raw_s1 <= '0;
      raw_s2 <= '0;
    end else begin
      raw_s1 <= raw_cmp;
      raw_s2 <= raw_s1;
    end

  genvar i;
  generate
    for (i = 0; i < N_CMP; i++) begin : g_ch
      logic rise_ev, fall_ev, set_ev;

      assign pol_val[i] = (cfg_en[i] & raw_s2[i]) ^ cfg_pol[i];

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        held[i] <= 1'b0;
        else if (tmr_fall) held[i] <= pol_val[i];

      assign cmp_out[i] = cfg_sync[i] ? held[i] : pol_val[i];
      assign pin_out[i] = cmp_out[i] & cfg_oe[i];

      assign rise_ev = cmp_out[i] & ~hist[i];
      assign fall_ev = ~cmp_out[i] & hist[i];
      assign set_ev  = (rise_ev & cfg_int_rise[i]) | (fall_ev & cfg_int_fall[i]);

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          hist[i]     <= 1'b0;
          irq_flag[i] <= 1'b0;
        end else begin
          hist[i]     <= cmp_out[i];
          irq_flag[i] <= set_ev | (irq_flag[i] & ~flag_clr[i]);
        end

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag[i] && !flag_clr[i]) |=> irq_flag[i]); // R6

      AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_out[i] && !hist[i] && cfg_int_rise[i]) ||
         (!cmp_out[i] && hist[i] && cfg_int_fall[i])) |=> irq_flag[i]); // R4

      AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flag[i] && (cmp_out[i] == hist[i])) |=> !irq_flag[i]); // R5

      AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_fall |=> $stable(held[i])); // R3
    end
  endgenerate

  generate
    if (PAD_W > 0) begin : g_pad
      assign mirror = {{PAD_W{1'b0}}, cmp_out};
    end else begin : g_nopad
      assign mirror = cmp_out[MIRROR_W-1:0];
    end
  endgenerate

endmodule

// File: tb/sim_cmp_cond.sv
module sim_cmp_cond;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] raw_cmp = '0, cfg_en = '0, cfg_pol = '0, cfg_oe = '0, cfg_sync = '0;
  logic [1:0] cfg_int_rise = '0, cfg_int_fall = '0, flag_clr = '0;
  logic tmr_clk = 1'b0;
  logic [1:0] cmp_out, pin_out, irq_flag;
  logic [7:0] mirror;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_cond u0 (.clk, .rst_n, .raw_cmp, .tmr_clk, .cfg_en, .cfg_pol, .cfg_oe,
    .cfg_sync, .cfg_int_rise, .cfg_int_fall, .flag_clr, .cmp_out, .pin_out,
    .mirror, .irq_flag);

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    flag_clr = 2'b11; wait_n(1); flag_clr = 2'b00; wait_n(1);
  endtask

  task automatic t_reset();
    check("R1 flags", {6'd0, irq_flag}, 8'd0);
    check("R1 out", {6'd0, cmp_out}, 8'd0);
    check("R1 mirror", mirror, 8'd0);
  endtask

  task automatic t_polarity();
    cfg_en = 2'b11; raw_cmp = 2'b01; wait_n(1);
    check("R2 latency", {6'd0, cmp_out}, 8'd0);
    wait_n(1);
    check("R2 follow", {6'd0, cmp_out}, 8'h01);
    cfg_pol = 2'b01; wait_n(1);
    check("R2 invert", {6'd0, cmp_out}, 8'h00);
    raw_cmp = 2'b00; wait_n(3);
    check("R2 invert low", {6'd0, cmp_out}, 8'h01);
    cfg_pol = 2'b00; wait_n(1);
    check("R2 restore", {6'd0, cmp_out}, 8'h00);
  endtask

  task automatic t_mirror();
    raw_cmp = 2'b10; wait_n(3);
    check("R9 mirror b1", mirror, 8'h02);
    raw_cmp = 2'b11; wait_n(3);
    check("R9 mirror both", mirror, 8'h03);
    raw_cmp = 2'b00; wait_n(3);
    check("R9 mirror zero", mirror, 8'h00);
  endtask

  task automatic t_pin();
    cfg_en = 2'b11; raw_cmp = 2'b11; cfg_oe = 2'b00; wait_n(3);
    check("R8 gated off", {6'd0, pin_out}, 8'h00);
    cfg_oe = 2'b10; wait_n(1);
    check("R8 one on", {6'd0, pin_out}, 8'h02);
    cfg_en = 2'b00; cfg_pol = 2'b10; wait_n(1);
    check("R8 disabled pin", {6'd0, pin_out}, 8'h02);
    cfg_pol = 2'b00; cfg_oe = 2'b00; raw_cmp = 2'b00; cfg_en = 2'b11; wait_n(3);
  endtask

  task automatic t_rise();
    clear_flags();
    cfg_int_rise = 2'b00; raw_cmp = 2'b01; wait_n(4);
    check("R4 rise disabled", {6'd0, irq_flag}, 8'h00);
    raw_cmp = 2'b00; wait_n(4);
    check("R5 fall disabled", {6'd0, irq_flag}, 8'h00);
    cfg_int_rise = 2'b01; raw_cmp = 2'b01; wait_n(2);
    check("R4 not yet", {6'd0, irq_flag}, 8'h00);
    wait_n(1);
    check("R4 rise sets", {6'd0, irq_flag}, 8'h01);
    wait_n(5);
    check("R6 sticky", {6'd0, irq_flag}, 8'h01);
    clear_flags();
    check("R6 cleared", {6'd0, irq_flag}, 8'h00);
    raw_cmp = 2'b00; wait_n(4);
    check("R4 fall ignored", {6'd0, irq_flag}, 8'h00);
    cfg_int_rise = 2'b00;
  endtask

  task automatic t_fall();
    clear_flags();
    cfg_int_fall = 2'b10; raw_cmp = 2'b10; wait_n(4);
    check("R5 rise ignored", {6'd0, irq_flag}, 8'h00);
    raw_cmp = 2'b00; wait_n(4);
    check("R5 fall sets", {6'd0, irq_flag}, 8'h02);
    cfg_int_fall = 2'b00; clear_flags();
  endtask

  task automatic t_collide();
    cfg_en = 2'b00; cfg_int_rise = 2'b01; cfg_int_fall = 2'b01;
    wait_n(1); clear_flags();
    cfg_pol = 2'b01; wait_n(1);
    check("R7 pol toggle out", {6'd0, cmp_out}, 8'h01);
    check("R7 pol toggle flag", {6'd0, irq_flag}, 8'h01);
    cfg_pol = 2'b00; flag_clr = 2'b01; wait_n(1); flag_clr = 2'b00;
    check("R6 edge beats clear", {6'd0, irq_flag}, 8'h01);
    clear_flags();
    check("R6 clear alone", {6'd0, irq_flag}, 8'h00);
    raw_cmp = 2'b01; wait_n(3);
    check("R7 disabled forced", {6'd0, cmp_out}, 8'h00);
    cfg_en = 2'b01; wait_n(1);
    check("R7 enable toggle flag", {6'd0, irq_flag}, 8'h01);
    cfg_int_rise = 0; cfg_int_fall = 0; raw_cmp = 0; cfg_en = 2'b11;
    wait_n(3); clear_flags();
  endtask

  task automatic t_sync();
    cfg_sync = 2'b01; wait_n(1);
    check("R3 sync hold init", {6'd0, cmp_out}, 8'h00);
    raw_cmp = 2'b11; wait_n(5);
    check("R3 raw alone", {6'd0, cmp_out}, 8'h02);
    tmr_clk = 1'b1; wait_n(5);
    check("R3 rise no capture", {6'd0, cmp_out}, 8'h02);
    tmr_clk = 1'b0; wait_n(5);
    check("R3 fall captures", {6'd0, cmp_out}, 8'h03);
    raw_cmp = 2'b00; wait_n(5);
    check("R3 holds after raw", {6'd0, cmp_out}, 8'h01);
    cfg_sync = 2'b00; wait_n(1);
    check("R3 async pass", {6'd0, cmp_out}, 8'h00);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1; wait_n(2);
    t_reset();
    t_polarity();
    t_mirror();
    t_pin();
    t_rise();
    t_fall();
    t_collide();
    t_sync();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule